// File: doc/BRIEF.md
# Serial Bus Target Front End for a Wiper Control Chip

This block is the two-wire serial bus target (I2C) that sits in front of the register bank of a small digitally controlled potentiometer. It cleans up the raw clock and data lines and finds START and STOP conditions. It then accepts a 7-bit device identifier whose top five bits are fixed at 01010 and whose two low bits come from strap pins. It acknowledges the bytes it owns by pulling the data line low through an open-drain enable.

A write transfer delivers a register address and one data byte. The block hands the pair to the register bank with a one-cycle write strobe. When the closing STOP arrives, it raises a separate one-cycle event so the bank can start a nonvolatile update. A combined read works in four steps: the master writes the address, issues a repeated START, and sends the identifier with the read bit set. The block then sends register bytes, MSB first, for as long as the master acknowledges them. Each byte it loads raises a read strobe. Addresses at or above the number of mapped registers read as 00h.

The register bank, the nonvolatile timing and the analog wiper are outside this block. The register bank supplies `reg_rdata` combinationally from `reg_addr`.

Top module: `dcp_i2c_target`

## Requirements
- R1: The identifier byte is accepted only when its seven upper bits equal 0,1,0,1,0,`strap_a[1]`,`strap_a[0]` (MSB first), and bit 0 is the direction (1 = read). On a mismatch the block does not acknowledge. It leaves SDA released and ignores the bus until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START is ignored while `por_done` is low. `por_done` only ever rises, and while it is low `sda_oe` stays low.
- R3: A pulse on SCL or SDA shorter than `FILT_NS` is rejected. A 30 ns pulse at a 100 MHz clock changes nothing.
- R4: In a write transfer the block acknowledges the identifier, the address byte and the data byte. In the cycle after the data byte's eighth bit completes, it pulses `reg_we` with `reg_addr` equal to the address byte and `reg_wdata` equal to the data byte.
- R5: A STOP that closes a transfer in which `reg_we` fired produces a one-cycle `stop_wr` pulse. Any other STOP produces none.
- R6: A second data byte in the same write transfer is not acknowledged and causes no `reg_we`.
- R7: In a read transfer (address write, repeated START, identifier with the read bit) the block sends the selected byte MSB first and pulses `reg_re` once per byte loaded. It keeps sending while the master acknowledges, and stops driving after a master NACK.
- R8: A read of any address at or above `NUM_REGS` (default 3) returns 00h, whatever `reg_rdata` holds.
- R9: After reset `sda_oe` is low. `sda_oe` only starts pulling SDA low while the filtered SCL is low.
- R10: `reg_we`, `reg_re` and `stop_wr` are single-cycle pulses, and `reg_we` and `reg_re` never fire together. All three are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_done | input | 1 | Power-up sequence finished; START is honoured only when high |
| strap_a | input | 2 | Strap pins giving the two low identifier bits |
| scl_i | input | 1 | Raw bus clock |
| sda_i | input | 1 | Raw bus data as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| reg_addr | output | 8 | Register address captured from the address byte |
| reg_wdata | output | 8 | Data byte for the register bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe, marks the byte loaded for sending |
| stop_wr | output | 1 | One-cycle event on a STOP that ends a write |
| reg_rdata | input | 8 | Register contents for `reg_addr` |

## Verification
The transfer engine is tried with four kinds of traffic:
- A plain write, a write followed by a surplus byte, and combined reads of one mapped and one unmapped address. These separate correct byte framing from off-by-one bit counting and show whether the read-back comes from the bank or is zeroed.
- Identifiers that differ only in a strap bit, checked before and after the straps change. These show that matching follows the pins rather than a constant.
- A START sent before power-up completes, which tells an honoured START apart from an ignored one.
- Sub-threshold spikes on SDA while the clock is high, and on SCL mid-byte. If a spike got through, it would create a false START or STOP or an extra bit, and the logged address or data would come out corrupted.

// File: rtl/dcp_i2c_target.sv
module dcp_i2c_target #(
  parameter int         CLK_HZ    = 100_000_000,
  parameter int         FILT_NS   = 50,
  parameter int         NUM_REGS  = 3,
  parameter logic [4:0] ID_PREFIX = 5'b01010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_done,
  input  logic [1:0] strap_a,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_re,
  output logic       stop_wr,
  input  logic [7:0] reg_rdata
);

  localparam int FILT_CYC = ((CLK_HZ / 1000) * FILT_NS + 999_999) / 1_000_000;
  localparam int FCYC     = (FILT_CYC < 1) ? 1 : FILT_CYC;
  localparam int FW       = $clog2(FCYC + 1);
  localparam logic [FW-1:0] FLIM    = FW'(FCYC - 1);
  localparam logic [8:0]    REG_LIM = 9'(NUM_REGS);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_ID_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
  } st_t;

  logic [1:0]         raw, s1, s2, filt, filt_q;
  logic [1:0][FW-1:0] fcnt;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g]   <= 1'b1;
        s2[g]   <= 1'b1;
        filt[g] <= 1'b1;
        fcnt[g] <= '0;
      end else begin
        s1[g] <= raw[g];
        s2[g] <= s1[g];
        if (s2[g] == filt[g]) begin
          fcnt[g] <= '0;
        end else if (fcnt[g] == FLIM) begin
          filt[g] <= s2[g];
          fcnt[g] <= '0;
        end else begin
          fcnt[g] <= fcnt[g] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= 2'b11;
    else        filt_q <= filt;
  end

  logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;
  assign scl_f    = filt[1];
  assign sda_f    = filt[0];
  assign scl_rise = scl_f & ~filt_q[1];
  assign scl_fall = ~scl_f & filt_q[1];
  assign start_c  = scl_f & filt_q[1] & filt_q[0] & ~sda_f;
  assign stop_c   = scl_f & filt_q[1] & ~filt_q[0] & sda_f;

  st_t        state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rd_dir, m_ack, wrote;
  logic [7:0] rsel;

  assign rsel = ({1'b0, reg_addr} < REG_LIM) ? reg_rdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      rd_dir    <= 1'b0;
      m_ack     <= 1'b0;
      wrote     <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      stop_wr   <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      reg_re  <= 1'b0;
      stop_wr <= 1'b0;
      if (start_c && por_done) begin
        state  <= ST_ID;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        stop_wr <= wrote;
        wrote   <= 1'b0;
      end else begin
        case (state)
          ST_ID, ST_ADDR, ST_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_ID) begin
                if (sh[7:1] == {ID_PREFIX, strap_a}) begin
                  state  <= ST_ID_ACK;
                  sda_oe <= 1'b1;
                  rd_dir <= sh[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_ADDR) begin
                reg_addr <= sh;
                state    <= ST_ADDR_ACK;
                sda_oe   <= 1'b1;
              end else begin
                reg_wdata <= sh;
                reg_we    <= 1'b1;
                wrote     <= 1'b1;
                state     <= ST_WDAT_ACK;
                sda_oe    <= 1'b1;
              end
            end
          end
          ST_ID_ACK: begin
            if (scl_fall) begin
              if (rd_dir) begin
                state  <= ST_RDAT;
                sh     <= rsel;
                sda_oe <= ~rsel[7];
                reg_re <= 1'b1;
                cnt    <= '0;
              end else begin
                state  <= ST_ADDR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              state  <= ST_WDAT;
              sda_oe <= 1'b0;
            end
          end
          ST_WDAT_ACK: begin
            if (scl_fall) begin
              state  <= ST_IDLE;
              sda_oe <= 1'b0;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                state  <= ST_RACK;
                sda_oe <= 1'b0;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (m_ack) begin
                state  <= ST_RDAT;
                sh     <= rsel;
                sda_oe <= ~rsel[7];
                reg_re <= 1'b1;
                cnt    <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dcp_i2c_target_chk.sv
module dcp_i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_done,
  input logic       scl_f,
  input logic       sda_oe,
  input logic       reg_we,
  input logic       reg_re,
  input logic       stop_wr,
  input logic [7:0] reg_addr
);

  AST_SILENT_BEFORE_POR: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |-> !sda_oe); // R2

  AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f); // R9

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R10

  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re)); // R10

  AST_STOPWR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> !stop_wr); // R5

  AST_ADDR_HELD_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr)); // R4

endmodule

bind dcp_i2c_target dcp_i2c_target_chk u_chk (.*);

// File: tb/test_dcp_i2c_target.sv
module test_dcp_i2c_target;

  localparam int Q = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_done = 1'b0;
  logic [1:0] strap_a = 2'b10;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, reg_we, reg_re, stop_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_bus;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  always_comb begin
    case (reg_addr)
      8'h00:   reg_rdata = 8'h3C;
      8'h01:   reg_rdata = 8'hC5;
      8'h02:   reg_rdata = 8'h5A;
      default: reg_rdata = 8'hEE;
    endcase
  end

  dcp_i2c_target i_dcp_i2c_target (
    .clk(clk), .rst_n(rst_n), .por_done(por_done), .strap_a(strap_a),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .stop_wr(stop_wr), .reg_rdata(reg_rdata)
  );

  typedef struct {
    int         kind;
    logic [7:0] a;
    logic [7:0] d;
    string      req;
  } ev_t;

  ev_t exp_q[$];
  ev_t got;
  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push(input int kind, input logic [7:0] a, input logic [7:0] d, input string req);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // kinds: 0 write strobe, 1 read strobe, 2 stop-after-write
  always @(negedge clk) begin
    if (rst_n && (reg_we || reg_re || stop_wr)) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected strobe", {29'd0, reg_we, reg_re, stop_wr}, 32'd0);
      end else begin
        got = exp_q.pop_front();
        if (got.kind == 0) begin
          check({got.req, " write strobe"}, {23'd0, reg_we, reg_addr, reg_wdata}, {23'd0, 1'b1, got.a, got.d});
        end else if (got.kind == 1) begin
          check({got.req, " read strobe"}, {23'd0, reg_re, reg_addr, 8'd0}, {23'd0, 1'b1, got.a, 8'd0});
        end else begin
          check({got.req, " stop event"}, {31'd0, stop_wr}, 32'd1);
        end
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq();
      if (gl && i == 2) begin
        repeat (5) @(negedge clk);
        sda_m = ~sda_m;
        repeat (3) @(negedge clk);
        sda_m = ~sda_m;
      end
      wq();
      scl_m = 1'b0;
      if (gl && i == 4) begin
        repeat (12) @(negedge clk);
        scl_m = 1'b1;
        repeat (3) @(negedge clk);
        scl_m = 1'b0;
      end
      wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = !sda_bus;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_m = 1'b1; wq();
      d[i] = sda_bus;
      wq();
      scl_m = 1'b0; wq();
    end
    sda_m = !mack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] id, input logic [7:0] a, input logic [7:0] d,
                          input bit gl, input string req);
    bit ack;
    push(0, a, d, req);
    push(2, 8'h00, 8'h00, "R5");
    bus_start();
    send_byte(id, 1'b0, ack); check({req, " id ack"}, {31'd0, ack}, 32'd1);
    send_byte(a, gl, ack);    check({req, " addr ack"}, {31'd0, ack}, 32'd1);
    send_byte(d, 1'b0, ack);  check({req, " data ack"}, {31'd0, ack}, 32'd1);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] a, input int nbytes, input logic [7:0] expd,
                         input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'h54, 1'b0, ack); check({req, " wr id ack"}, {31'd0, ack}, 32'd1);
    send_byte(a, 1'b0, ack);     check({req, " addr ack"}, {31'd0, ack}, 32'd1);
    bus_start();
    for (int k = 0; k < nbytes; k++) push(1, a, 8'h00, req);
    send_byte(8'h55, 1'b0, ack); check({req, " rd id ack"}, {31'd0, ack}, 32'd1);
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(k != nbytes - 1, d);
      check({req, " read byte"}, {24'd0, d}, {24'd0, expd});
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    repeat (20) @(negedge clk);
    check("R9 reset sda_oe", {31'd0, sda_oe}, 32'd0);
    check("R10 reset strobes", {29'd0, reg_we, reg_re, stop_wr}, 32'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 idle sda_oe", {31'd0, sda_oe}, 32'd0);

    // R2: START before power-up completes is ignored
    bus_start();
    send_byte(8'h54, 1'b0, ack); check("R2 id before por", {31'd0, ack}, 32'd0);
    bus_stop();
    por_done = 1'b1;
    repeat (10) @(negedge clk);

    // R4 R5: basic write
    do_write(8'h54, 8'h01, 8'h9A, 1'b0, "R4");

    // R1: wrong strap bit in identifier, then bus ignored
    bus_start();
    send_byte(8'h56, 1'b0, ack); check("R1 mismatch id nack", {31'd0, ack}, 32'd0);
    send_byte(8'h01, 1'b0, ack); check("R1 ignored after mismatch", {31'd0, ack}, 32'd0);
    bus_stop();

    // R6: surplus data byte
    push(0, 8'h02, 8'h33, "R6");
    push(2, 8'h00, 8'h00, "R5");
    bus_start();
    send_byte(8'h54, 1'b0, ack); check("R6 id ack", {31'd0, ack}, 32'd1);
    send_byte(8'h02, 1'b0, ack); check("R6 addr ack", {31'd0, ack}, 32'd1);
    send_byte(8'h33, 1'b0, ack); check("R6 data ack", {31'd0, ack}, 32'd1);
    send_byte(8'h44, 1'b0, ack); check("R6 extra byte nack", {31'd0, ack}, 32'd0);
    bus_stop();

    // R7: combined read of a mapped register, three bytes
    do_read(8'h00, 3, 8'h3C, "R7");
    // R8: unmapped address reads zero
    do_read(8'h05, 2, 8'h00, "R8");
    // R7: longer stream from another register
    do_read(8'h02, 4, 8'h5A, "R7");

    // R1: strap change moves the identifier
    strap_a = 2'b01;
    repeat (10) @(negedge clk);
    bus_start();
    send_byte(8'h54, 1'b0, ack); check("R1 old id nack", {31'd0, ack}, 32'd0);
    bus_stop();
    do_write(8'h52, 8'h01, 8'h11, 1'b0, "R1");

    // R3: short SDA dip with SCL high is not a START
    repeat (5) @(negedge clk);
    sda_m = 1'b0;
    repeat (3) @(negedge clk);
    sda_m = 1'b1;
    repeat (10) @(negedge clk);
    scl_m = 1'b0; wq();
    send_byte(8'h52, 1'b0, ack); check("R3 sda spike not start", {31'd0, ack}, 32'd0);
    bus_stop();

    // R3: spikes on both lines inside the address byte
    do_write(8'h52, 8'h02, 8'h77, 1'b1, "R3");

    repeat (50) @(negedge clk);
    check("R7 all expected strobes seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule